// File: doc/BRIEF.md
# CPU-to-Debugger Mailbox Register

This block holds one byte that running firmware writes for an external debugger to collect. The CPU reaches it through a small I/O port with address, write strobe, read strobe and byte-wide data. The debugger has its own read strobe and sees the stored byte on a dedicated output. A pending flag rises whenever firmware stores a new byte. It stays up until the debugger reads, so the debugger knows fresh data is waiting. When firmware reads the location back, the pending flag stands in bit 7 and the stored byte supplies the low seven bits.

The mailbox can share its I/O address with a plain general-purpose register. The mailbox answers only when the on-chip-debug fuse is programmed and the debugger has opened access. In every other case the plain register answers at that address.

A small interlock guards requests to program the on-chip-debug fuse. The request is refused while either lock bit is programmed, and a chip erase lifts that refusal. The block also combines the test-port enable fuse with a disable control bit to produce the test-port enable.

Top module: `dbg_mailbox`

## Requirements
- R1: After synchronous active-high reset, the stored byte, the pending flag and the plain register are all 0, and the chip-erase record is cleared.
- R2: A CPU write that selects the mailbox stores the write data and sets the pending flag, both visible in the next cycle.
- R3: A CPU read that selects the mailbox returns, in the same cycle, the pending flag in bit 7 and bits 6..0 of the stored byte.
- R4: A debugger read clears the pending flag in the next cycle. The debugger data output always carries the full stored byte, including bit 7.
- R5: When a mailbox write and a debugger read fall in the same cycle, the write wins: the flag is set and the new byte is kept.
- R6: With sharing enabled, the mailbox is selected only when both the fuse and the debugger access enable are 1. Otherwise, a write to the shared address goes to the plain register and leaves the mailbox untouched, and a read there returns the plain register.
- R7: CPU accesses to any other address change nothing, and a read there returns 0.
- R8: A lock bit reads 1 when programmed. A fuse-program request made while either lock bit is 1 and no chip erase is recorded gives a grant of 0 in the next cycle. With both lock bits at 0, the grant is 1 in the next cycle.
- R9: A chip-erase pulse takes effect at the next clock edge. A request made in any later cycle, until reset, is granted whatever the lock bits are. A request made in the same cycle as the pulse is still judged on the old state.
- R10: The test-port enable is 1 exactly when its fuse input is 1 and the disable bit is 0.
- R11: CPU reads never clear the pending flag. Without a mailbox write or a debugger read, the flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 6 | CPU I/O address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational |
| dbg_rd | input | 1 | Debugger read strobe |
| dbg_rdata | output | 8 | Stored mailbox byte |
| dbg_dirty | output | 1 | Pending flag |
| ocd_fuse | input | 1 | On-chip-debug fuse programmed |
| dbg_access_en | input | 1 | Debugger has enabled mailbox access |
| lock_bits | input | 2 | Lock bit states, 1 = programmed |
| chip_erase | input | 1 | Chip erase pulse |
| fuse_wr_req | input | 1 | Request to program the on-chip-debug fuse |
| fuse_wr_ok | output | 1 | Grant for the previous cycle's request |
| jtag_fuse | input | 1 | Test-port enable fuse programmed |
| jtag_dis | input | 1 | Test-port disable control bit |
| tap_en | output | 1 | Test-port enable |

## Verification
Suppose the pending flag is stuck or clears at the wrong time. Firmware reads it in bit 7 one cycle after the next write, and the debugger status shows the same fault a cycle after a debugger read. If the address mux picks the wrong target, the effect shows in the first cycle after a shared-address write. The mailbox byte changes when it should not, or a read-back returns the plain register's value instead of the flagged view. If the interlock carries the wrong erase record, the grant of the very next request has the wrong value. The requests made in the same cycle as an erase and in the cycle just after it mark the boundary.

// File: rtl/dbg_mailbox_pkg.sv
`timescale 1ns/1ps
package dbg_mailbox_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] mbox;
        logic              dirty;
        logic [DATA_W-1:0] gp;
    } mbox_regs_t;

    typedef struct packed {
        logic erased;
        logic grant;
    } lock_regs_t;
endpackage

// File: rtl/mbox_decode.sv
`timescale 1ns/1ps
module mbox_decode #(
    parameter int                ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] MBOX_ADDR = 6'h31,
    parameter bit                SHARED    = 1'b1
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic              ocd_fuse,
    input  logic              dbg_access_en,
    output logic              mbox_wr,
    output logic              mbox_rd,
    output logic              gp_wr,
    output logic              gp_rd
);
    logic hit;
    logic to_mbox;

    assign hit = (cpu_addr == MBOX_ADDR);

    generate
        if (SHARED) begin : g_shared
            assign to_mbox = ocd_fuse & dbg_access_en;
        end else begin : g_private
            logic unused_sel;
            assign unused_sel = ocd_fuse ^ dbg_access_en;
            assign to_mbox    = 1'b1;
        end
    endgenerate

    always_comb begin
        mbox_wr = hit & cpu_wr &  to_mbox;
        mbox_rd = hit & cpu_rd &  to_mbox;
        gp_wr   = hit & cpu_wr & ~to_mbox;
        gp_rd   = hit & cpu_rd & ~to_mbox;
    end
endmodule

// File: rtl/mbox_core.sv
`timescale 1ns/1ps
module mbox_core
    import dbg_mailbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mbox_wr,
    input  logic              gp_wr,
    input  logic              dbg_rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mbox_q,
    output logic              dirty_q,
    output logic [DATA_W-1:0] gp_q
);
    mbox_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (mbox_wr) begin
            r_d.mbox  = wdata;
            r_d.dirty = 1'b1;
        end else if (dbg_rd) begin
            r_d.dirty = 1'b0;
        end
        if (gp_wr) begin
            r_d.gp = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mbox_q  = r_q.mbox;
    assign dirty_q = r_q.dirty;
    assign gp_q    = r_q.gp;
endmodule

// File: rtl/mbox_lock.sv
`timescale 1ns/1ps
module mbox_lock
    import dbg_mailbox_pkg::*;
#(
    parameter int LOCK_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LOCK_N-1:0] lock_bits,
    input  logic              chip_erase,
    input  logic              fuse_wr_req,
    output logic              fuse_wr_ok
);
    lock_regs_t l_d, l_q;
    logic       locked;

    assign locked = (|lock_bits) & ~l_q.erased;

    always_comb begin
        l_d        = l_q;
        l_d.erased = l_q.erased | chip_erase;
        l_d.grant  = fuse_wr_req & ~locked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign fuse_wr_ok = l_q.grant;
endmodule

// File: rtl/dbg_mailbox.sv
`timescale 1ns/1ps
module dbg_mailbox
    import dbg_mailbox_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] MBOX_ADDR = 6'h31,
    parameter bit                SHARED    = 1'b1,
    parameter int                LOCK_N    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              dbg_rd,
    output logic [DATA_W-1:0] dbg_rdata,
    output logic              dbg_dirty,
    input  logic              ocd_fuse,
    input  logic              dbg_access_en,
    input  logic [LOCK_N-1:0] lock_bits,
    input  logic              chip_erase,
    input  logic              fuse_wr_req,
    output logic              fuse_wr_ok,
    input  logic              jtag_fuse,
    input  logic              jtag_dis,
    output logic              tap_en
);
    localparam int LOW_W = DATA_W - 1;

    logic              mbox_wr, mbox_rd, gp_wr, gp_rd;
    logic [DATA_W-1:0] mbox_q, gp_q;
    logic              dirty_q;

    mbox_decode #(
        .ADDR_W    (ADDR_W),
        .MBOX_ADDR (MBOX_ADDR),
        .SHARED    (SHARED)
    ) u_decode (
        .cpu_addr      (cpu_addr),
        .cpu_wr        (cpu_wr),
        .cpu_rd        (cpu_rd),
        .ocd_fuse      (ocd_fuse),
        .dbg_access_en (dbg_access_en),
        .mbox_wr       (mbox_wr),
        .mbox_rd       (mbox_rd),
        .gp_wr         (gp_wr),
        .gp_rd         (gp_rd)
    );

    mbox_core u_core (
        .clk     (clk),
        .rst     (rst),
        .mbox_wr (mbox_wr),
        .gp_wr   (gp_wr),
        .dbg_rd  (dbg_rd),
        .wdata   (cpu_wdata),
        .mbox_q  (mbox_q),
        .dirty_q (dirty_q),
        .gp_q    (gp_q)
    );

    mbox_lock #(
        .LOCK_N (LOCK_N)
    ) u_lock (
        .clk         (clk),
        .rst         (rst),
        .lock_bits   (lock_bits),
        .chip_erase  (chip_erase),
        .fuse_wr_req (fuse_wr_req),
        .fuse_wr_ok  (fuse_wr_ok)
    );

    always_comb begin
        if (mbox_rd) begin
            cpu_rdata = {dirty_q, mbox_q[LOW_W-1:0]};
        end else if (gp_rd) begin
            cpu_rdata = gp_q;
        end else begin
            cpu_rdata = '0;
        end
    end

    assign dbg_rdata = mbox_q;
    assign dbg_dirty = dirty_q;
    assign tap_en    = jtag_fuse & ~jtag_dis;
endmodule

// File: rtl/dbg_mailbox_chk.sv
`timescale 1ns/1ps
module dbg_mailbox_chk #(
    parameter int                ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] MBOX_ADDR = 6'h31,
    parameter bit                SHARED    = 1'b1,
    parameter int                LOCK_N    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [7:0]        cpu_wdata,
    input logic [7:0]        cpu_rdata,
    input logic              dbg_rd,
    input logic [7:0]        dbg_rdata,
    input logic              dbg_dirty,
    input logic              ocd_fuse,
    input logic              dbg_access_en,
    input logic [LOCK_N-1:0] lock_bits,
    input logic              chip_erase,
    input logic              fuse_wr_req,
    input logic              fuse_wr_ok
);
    logic sel, sel_wr, sel_rd, erased_c;

    assign sel    = (cpu_addr == MBOX_ADDR) && (!SHARED || (ocd_fuse && dbg_access_en));
    assign sel_wr = sel && cpu_wr;
    assign sel_rd = sel && cpu_rd;

    always_ff @(posedge clk) begin
        if (rst)             erased_c <= 1'b0;
        else if (chip_erase) erased_c <= 1'b1;
    end

    a_r2_write_sets_dirty: assert property (@(posedge clk) disable iff (rst)
        sel_wr |=> (dbg_dirty && dbg_rdata == $past(cpu_wdata)));
    a_r3_cpu_view: assert property (@(posedge clk) disable iff (rst)
        sel_rd |-> (cpu_rdata == {dbg_dirty, dbg_rdata[6:0]}));
    a_r4_dbg_read_clears: assert property (@(posedge clk) disable iff (rst)
        (dbg_rd && !sel_wr) |=> !dbg_dirty);
    a_r5_write_wins: assert property (@(posedge clk) disable iff (rst)
        (dbg_rd && sel_wr) |=> dbg_dirty);
    a_r6_mbox_untouched: assert property (@(posedge clk) disable iff (rst)
        !sel_wr |=> $stable(dbg_rdata));
    a_r7_other_addr_zero: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && cpu_addr != MBOX_ADDR) |-> (cpu_rdata == 8'h00));
    a_r8_locked_refused: assert property (@(posedge clk) disable iff (rst)
        (fuse_wr_req && (|lock_bits) && !erased_c) |=> !fuse_wr_ok);
    a_r9_erase_unlocks: assert property (@(posedge clk) disable iff (rst)
        (fuse_wr_req && erased_c) |=> fuse_wr_ok);
    a_r11_dirty_hold: assert property (@(posedge clk) disable iff (rst)
        (!sel_wr && !dbg_rd) |=> $stable(dbg_dirty));
endmodule

bind dbg_mailbox dbg_mailbox_chk #(
    .ADDR_W    (ADDR_W),
    .MBOX_ADDR (MBOX_ADDR),
    .SHARED    (SHARED),
    .LOCK_N    (LOCK_N)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_addr      (cpu_addr),
    .cpu_wr        (cpu_wr),
    .cpu_rd        (cpu_rd),
    .cpu_wdata     (cpu_wdata),
    .cpu_rdata     (cpu_rdata),
    .dbg_rd        (dbg_rd),
    .dbg_rdata     (dbg_rdata),
    .dbg_dirty     (dbg_dirty),
    .ocd_fuse      (ocd_fuse),
    .dbg_access_en (dbg_access_en),
    .lock_bits     (lock_bits),
    .chip_erase    (chip_erase),
    .fuse_wr_req   (fuse_wr_req),
    .fuse_wr_ok    (fuse_wr_ok)
);

// File: tb/dbg_mailbox_bench.sv
`timescale 1ns/1ps
module dbg_mailbox_bench;
    typedef struct {
        int         sel;   // 0 cpu_rdata, 1 dbg_rdata, 2 dirty, 3 grant, 4 tap_en
        logic [7:0] exp;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] cpu_addr = 6'h31;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0, dbg_rd = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata, dbg_rdata;
    logic       dbg_dirty, fuse_wr_ok, tap_en;
    logic       ocd_fuse = 1'b0, dbg_access_en = 1'b0;
    logic [1:0] lock_bits = 2'b00;
    logic       chip_erase = 1'b0, fuse_wr_req = 1'b0;
    logic       jtag_fuse = 1'b0, jtag_dis = 1'b0;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    always #2 clk = ~clk;

    dbg_mailbox u_dbg_mailbox (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dbg_rd(dbg_rd),
        .dbg_rdata(dbg_rdata), .dbg_dirty(dbg_dirty), .ocd_fuse(ocd_fuse),
        .dbg_access_en(dbg_access_en), .lock_bits(lock_bits), .chip_erase(chip_erase),
        .fuse_wr_req(fuse_wr_req), .fuse_wr_ok(fuse_wr_ok), .jtag_fuse(jtag_fuse),
        .jtag_dis(jtag_dis), .tap_en(tap_en)
    );

    // advance one clock; returns half a unit after the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #0.5;
    endtask

    task automatic expect_out(int sel, logic [7:0] exp, string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic idle();
        cpu_wr = 0; cpu_rd = 0; dbg_rd = 0; fuse_wr_req = 0; chip_erase = 0;
    endtask

    // monitor: compares queued expectations one unit after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.sel)
                    0: act = cpu_rdata;
                    1: act = dbg_rdata;
                    2: act = {7'd0, dbg_dirty};
                    3: act = {7'd0, fuse_wr_ok};
                    default: act = {7'd0, tap_en};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: sel %0d actual %02h expected %02h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(); step();
        // R1 reset state
        rst = 0; cpu_rd = 1;
        expect_out(1, 8'h00, "R1"); expect_out(2, 0, "R1");
        expect_out(3, 0, "R1");     expect_out(0, 8'h00, "R1");
        step();
        ocd_fuse = 1; dbg_access_en = 1; cpu_rd = 0;
        // R2 write stores byte, sets flag
        cpu_wr = 1; cpu_wdata = 8'hA5; step(); idle();
        expect_out(2, 1, "R2"); expect_out(1, 8'hA5, "R2");
        cpu_rd = 1; expect_out(0, 8'hA5, "R3");
        step(); idle();
        cpu_wr = 1; cpu_wdata = 8'h3C; step(); idle();
        cpu_rd = 1; expect_out(0, 8'hBC, "R3 flag in bit7");
        // R11 CPU read does not clear flag
        step(); step(); idle();
        expect_out(2, 1, "R11");
        // R4 debugger read clears flag
        dbg_rd = 1; step(); idle();
        expect_out(2, 0, "R4"); expect_out(1, 8'h3C, "R4");
        cpu_rd = 1; expect_out(0, 8'h3C, "R3 flag clear");
        step(); idle();
        cpu_wr = 1; cpu_wdata = 8'hF0; step(); idle();
        dbg_rd = 1; step(); idle();
        expect_out(1, 8'hF0, "R4 full byte");
        // R5 write and debugger read together
        cpu_wr = 1; dbg_rd = 1; cpu_wdata = 8'h81; step(); idle();
        expect_out(2, 1, "R5"); expect_out(1, 8'h81, "R5");
        step();
        expect_out(2, 1, "R11 hold");
        // R6 access enable off: plain register
        dbg_access_en = 0; cpu_wr = 1; cpu_wdata = 8'h55; step(); idle();
        expect_out(1, 8'h81, "R6"); expect_out(2, 1, "R6");
        cpu_rd = 1; expect_out(0, 8'h55, "R6"); step(); idle();
        ocd_fuse = 0; dbg_access_en = 1; cpu_wr = 1; cpu_wdata = 8'h66; step(); idle();
        expect_out(1, 8'h81, "R6 fuse"); cpu_rd = 1; expect_out(0, 8'h66, "R6 fuse");
        step(); idle();
        ocd_fuse = 1; cpu_rd = 1; expect_out(0, 8'h81, "R6 reselect");
        step(); idle();
        // R7 other address
        cpu_addr = 6'h10; cpu_wr = 1; cpu_wdata = 8'h77; step(); idle();
        expect_out(1, 8'h81, "R7"); cpu_rd = 1; expect_out(0, 8'h00, "R7");
        step(); idle(); cpu_addr = 6'h31;
        ocd_fuse = 0; cpu_rd = 1; expect_out(0, 8'h66, "R7 plain kept");
        step(); idle(); ocd_fuse = 1;
        // R8 lock interlock
        lock_bits = 2'b01; fuse_wr_req = 1; step(); expect_out(3, 0, "R8 lock0");
        lock_bits = 2'b10; step(); expect_out(3, 0, "R8 lock1");
        lock_bits = 2'b00; step(); expect_out(3, 1, "R8 unlocked");
        fuse_wr_req = 0; step(); expect_out(3, 0, "R8 no req");
        // R9 chip erase
        lock_bits = 2'b11; fuse_wr_req = 1; chip_erase = 1; step();
        expect_out(3, 0, "R9 same cycle");
        chip_erase = 0; step(); expect_out(3, 1, "R9 after erase");
        idle(); step();
        // R10 test-port enable
        jtag_fuse = 0; jtag_dis = 0; #0.1 expect_out(4, 0, "R10");
        step(); jtag_fuse = 1; jtag_dis = 0; expect_out(4, 1, "R10");
        step(); jtag_fuse = 1; jtag_dis = 1; expect_out(4, 0, "R10");
        step(); jtag_fuse = 0; jtag_dis = 1; expect_out(4, 0, "R10");
        step();
        // R1 reset again
        rst = 1; step(); rst = 0;
        expect_out(1, 8'h00, "R1"); expect_out(2, 0, "R1");
        cpu_rd = 1; ocd_fuse = 0; expect_out(0, 8'h00, "R1 plain");
        step(); idle(); ocd_fuse = 1;
        fuse_wr_req = 1; step(); expect_out(3, 0, "R1 erase cleared");
        idle(); step(); step();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule